// File: doc/BRIEF.md
# Floating-Point Dual-Issue Scheduler

This block sits in the dispatch stage in front of a pipelined floating-point unit. The decoder offers it two instruction slots each cycle. One holds an integer or load/store instruction and the other a floating-point instruction. The scheduler decides, combinationally and within the same cycle, which of the two may leave dispatch. A floating-point operation goes out next to its integer/memory partner whenever the unit can take it. The arithmetic is not modelled. Each operation is a delay that ends in a one-cycle result pulse carrying its destination register number.

Three kinds of state gate a floating-point issue. A per-class repeat counter keeps a class from re-entering the unit before its minimum spacing, so a long square root blocks the next square root for most of its run. A write-back reservation line, one entry per cycle of the longest latency, records when each in-flight result will be written and to which register. The scheduler reads that line in two ways. It refuses an operation whose result would land in a cycle that is already taken. It also refuses an operation that reads a register still pending in the line. A synchronous flush empties all of this state.

A `fp_first` input tells the scheduler which slot is older. When the floating-point instruction is older and blocked, the integer/memory instruction waits with it. When the integer/memory instruction is older, it issues alone.

Top module: `fpu_issue_sched`

## Requirements
- R1: After reset no result pulse is present, and with no valid instruction `stall` is low and `fp_ready` is high for any operation.
- R2: A floating-point instruction and an integer/memory instruction issue in the same cycle when neither is blocked. The block has only one integer/memory slot.
- R3: With `fp_first`=1, a valid floating-point instruction that cannot issue also holds back the integer/memory instruction. With `fp_first`=0, the integer/memory instruction issues regardless of the floating-point slot.
- R4: An operation issued in cycle t raises `res_valid` in cycle t+L, with `res_dst` equal to its destination. The `fp_op` code sets L: 0 = single multiply, L=4; 1 = double multiply, L=5; 2 = double square root, L=32; 3 = double add, L=3.
- R5: After an issue, the next operation of the same code may issue no sooner than the repeat interval: 1 cycle for codes 0 and 3, 2 cycles for code 1, 29 cycles for code 2.
- R6: An operation whose `fp_src_a` or `fp_src_b` equals the destination of an in-flight operation waits until the cycle after that operation's result pulse.
- R7: At most one result is written per cycle. An operation whose result would land in an occupied cycle does not issue.
- R8: While `flush` is high nothing issues. From the next cycle on, no earlier operation produces a result, blocks a source, or holds a repeat interval.
- R9: `stall` is high exactly when a valid instruction in either slot is not issued in that cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| flush | input | 1 | Synchronous clear of all in-flight state; blocks issue this cycle |
| im_valid | input | 1 | Integer/memory slot holds an instruction |
| im_ready | output | 1 | Integer/memory slot may issue |
| im_issue | output | 1 | Integer/memory instruction issues this cycle |
| fp_valid | input | 1 | Floating-point slot holds an instruction |
| fp_first | input | 1 | 1 when the floating-point instruction is the older of the pair |
| fp_op | input | 2 | Operation code (see R4) |
| fp_dst | input | 5 | Destination register |
| fp_src_a | input | 5 | First source register |
| fp_src_b | input | 5 | Second source register |
| fp_ready | output | 1 | Floating-point slot may issue |
| fp_issue | output | 1 | Floating-point operation issues this cycle |
| stall | output | 1 | A valid instruction was held back this cycle |
| res_valid | output | 1 | A result is written this cycle |
| res_dst | output | 5 | Destination register of the result being written |

## Verification
A wrong entry in the reservation line shows at the ports in one of two ways. If the entry is lost, the result pulse never arrives. If the entry is placed in the wrong cell, the pulse arrives early or late. A stale entry appears at once as a refused `fp_ready` on a dependent source, and later as a double or phantom pulse. A repeat counter that is off by one shows in the single cycle at the edge of the repeat window. The model therefore compares every output on every cycle, so such a fault is reported in the cycle it first reaches a port.

// File: rtl/fis_pkg.sv
package fis_pkg;

    typedef enum logic [1:0] {
        OP_MUL_S  = 2'd0,
        OP_MUL_D  = 2'd1,
        OP_SQRT_D = 2'd2,
        OP_ADD_D  = 2'd3
    } fp_op_e;

    localparam int NUM_OPS = 4;
    localparam int LAT_MAX = 32;
    localparam int REP_MAX = 29;
    localparam int REP_W   = $clog2(REP_MAX + 1);
    localparam int REG_W   = 5;

    typedef struct packed {
        logic             v;
        logic [REG_W-1:0] dst;
    } wb_slot_t;

    function automatic int op_latency(fp_op_e op);
        case (op)
            OP_MUL_S:  return 4;
            OP_MUL_D:  return 5;
            OP_SQRT_D: return 32;
            default:   return 3;
        endcase
    endfunction

    function automatic int op_repeat(fp_op_e op);
        case (op)
            OP_MUL_D:  return 2;
            OP_SQRT_D: return 29;
            default:   return 1;
        endcase
    endfunction

endpackage

// File: rtl/fis_rep_ctr.sv
module fis_rep_ctr #(
    parameter int W = 5
) (
    input  logic         clk,
    input  logic         rst,
    input  logic         flush,
    input  logic         load,
    input  logic [W-1:0] reload,
    output logic         idle
);
    logic [W-1:0] cnt;

    always_ff @(posedge clk) begin
        if (rst || flush)    cnt <= '0;
        else if (load)       cnt <= reload;
        else if (cnt != '0)  cnt <= cnt - 1'b1;
    end

    assign idle = (cnt == '0);

    AST_REP_GAP: assert property (@(posedge clk) disable iff (rst) load |-> idle); // R5
    AST_REP_FLUSH: assert property (@(posedge clk) disable iff (rst) flush |=> idle); // R8

endmodule

// File: rtl/fis_wb_sched.sv
module fis_wb_sched
    import fis_pkg::*;
#(
    parameter  int DEPTH = LAT_MAX,
    localparam int LW    = $clog2(DEPTH + 1)
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             flush,
    input  logic             issue,
    input  logic [LW-1:0]    lat,
    input  logic [REG_W-1:0] dst,
    input  logic [REG_W-1:0] src_a,
    input  logic [REG_W-1:0] src_b,
    output logic             slot_busy,
    output logic             raw_hit,
    output logic             res_valid,
    output logic [REG_W-1:0] res_dst
);
    wb_slot_t slots [DEPTH];

    always_comb begin
        slot_busy = 1'b0;
        raw_hit   = 1'b0;
        for (int i = 0; i < DEPTH; i++) begin
            if (slots[i].v && i == int'(lat)) slot_busy = 1'b1;
            if (slots[i].v && (slots[i].dst == src_a || slots[i].dst == src_b)) raw_hit = 1'b1;
        end
    end

    always_ff @(posedge clk) begin
        for (int i = 0; i < DEPTH; i++) begin
            if (rst || flush) begin
                slots[i] <= '0;
            end else begin
                slots[i] <= (i + 1 < DEPTH) ? slots[(i + 1) % DEPTH] : '0;
                if (issue && i == int'(lat) - 1) slots[i] <= '{v: 1'b1, dst: dst};
            end
        end
    end

    assign res_valid = slots[0].v;
    assign res_dst   = slots[0].dst;

    // checker state: where the last issue should have landed
    logic             issue_q;
    logic [LW-1:0]    lat_q;
    logic [REG_W-1:0] dst_q;
    wb_slot_t         land;

    always_ff @(posedge clk) begin
        if (rst) begin
            issue_q <= 1'b0;
            lat_q   <= '0;
            dst_q   <= '0;
        end else begin
            issue_q <= issue;
            lat_q   <= lat;
            dst_q   <= dst;
        end
    end

    always_comb begin
        land = '0;
        for (int i = 0; i < DEPTH; i++)
            if (i == int'(lat_q) - 1) land = slots[i];
    end

    AST_WB_LAND: assert property (@(posedge clk) disable iff (rst) issue_q |-> (land.v && land.dst == dst_q)); // R4
    AST_ONE_WB: assert property (@(posedge clk) disable iff (rst) issue |-> !slot_busy); // R7
    AST_NO_RAW: assert property (@(posedge clk) disable iff (rst) issue |-> !raw_hit); // R6
    AST_FLUSH_CLR: assert property (@(posedge clk) disable iff (rst) flush |=> !res_valid && !raw_hit); // R8

endmodule

// File: rtl/fpu_issue_sched.sv
module fpu_issue_sched
    import fis_pkg::*;
#(
    parameter  int DEPTH = LAT_MAX,
    localparam int LW    = $clog2(DEPTH + 1)
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             flush,
    input  logic             im_valid,
    output logic             im_ready,
    output logic             im_issue,
    input  logic             fp_valid,
    input  logic             fp_first,
    input  logic [1:0]       fp_op,
    input  logic [REG_W-1:0] fp_dst,
    input  logic [REG_W-1:0] fp_src_a,
    input  logic [REG_W-1:0] fp_src_b,
    output logic             fp_ready,
    output logic             fp_issue,
    output logic             stall,
    output logic             res_valid,
    output logic [REG_W-1:0] res_dst
);
    logic [NUM_OPS-1:0] rep_idle;
    logic               slot_busy;
    logic               raw_hit;
    logic               fp_can;
    logic [LW-1:0]      lat;

    assign lat = LW'(op_latency(fp_op_e'(fp_op)));

    for (genvar g = 0; g < NUM_OPS; g++) begin : g_rep
        fis_rep_ctr #(.W(REP_W)) u_rep (
            .clk    (clk),
            .rst    (rst),
            .flush  (flush),
            .load   (fp_issue && fp_op == 2'(g)),
            .reload (REP_W'(op_repeat(fp_op_e'(g)) - 1)),
            .idle   (rep_idle[g])
        );
    end

    fis_wb_sched #(.DEPTH(DEPTH)) u_wb (
        .clk       (clk),
        .rst       (rst),
        .flush     (flush),
        .issue     (fp_issue),
        .lat       (lat),
        .dst       (fp_dst),
        .src_a     (fp_src_a),
        .src_b     (fp_src_b),
        .slot_busy (slot_busy),
        .raw_hit   (raw_hit),
        .res_valid (res_valid),
        .res_dst   (res_dst)
    );

    assign fp_can   = rep_idle[fp_op] && !raw_hit && !slot_busy;
    assign fp_ready = !flush && fp_can;
    assign fp_issue = fp_valid && fp_ready;
    assign im_ready = !flush && (!(fp_valid && fp_first) || fp_can);
    assign im_issue = im_valid && im_ready;
    assign stall    = (fp_valid && !fp_issue) || (im_valid && !im_issue);

    AST_ORDER: assert property (@(posedge clk) disable iff (rst) (fp_valid && fp_first && !fp_issue) |-> !im_issue); // R3
    AST_FLUSH_QUIET: assert property (@(posedge clk) disable iff (rst) flush |-> !(fp_issue || im_issue)); // R8
    AST_STALL: assert property (@(posedge clk) disable iff (rst) (im_issue && (fp_issue || !fp_valid)) |-> !stall); // R9

endmodule

// File: tb/fpu_issue_sched_tb.sv
`timescale 1ns/1ps
module fpu_issue_sched_tb_top;
    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       flush = 1'b0;
    logic       im_valid = 1'b0, fp_valid = 1'b0, fp_first = 1'b0;
    logic [1:0] fp_op = 2'd0;
    logic [4:0] fp_dst = '0, fp_src_a = '0, fp_src_b = '0;
    logic       im_ready, im_issue, fp_ready, fp_issue, stall, res_valid;
    logic [4:0] res_dst;

    int total = 0;
    int bad = 0;
    int cyc = 0;
    bit done = 0;

    int due_q[$];
    int dst_q[$];
    int last_iss[4];

    always #2.5 clk = ~clk;

    fpu_issue_sched dut_i (
        .clk(clk), .rst(rst), .flush(flush),
        .im_valid(im_valid), .im_ready(im_ready), .im_issue(im_issue),
        .fp_valid(fp_valid), .fp_first(fp_first), .fp_op(fp_op),
        .fp_dst(fp_dst), .fp_src_a(fp_src_a), .fp_src_b(fp_src_b),
        .fp_ready(fp_ready), .fp_issue(fp_issue), .stall(stall),
        .res_valid(res_valid), .res_dst(res_dst)
    );

    function automatic int m_lat(int op);
        if (op == 0) return 4;
        if (op == 1) return 5;
        if (op == 2) return 32;
        return 3;
    endfunction

    function automatic int m_rep(int op);
        if (op == 1) return 2;
        if (op == 2) return 29;
        return 1;
    endfunction

    task automatic chk(int act, int exp, string tag, string what);
        total++;
        if (act != exp) begin
            bad++;
            $display("FAIL %s %s cycle %0d: actual=%0d expected=%0d", tag, what, cyc, act, exp);
        end
    endtask

    task automatic model_clear();
        due_q.delete();
        dst_q.delete();
        for (int k = 0; k < 4; k++) last_iss[k] = -1000;
    endtask

    task automatic step(bit imv, bit fpv, bit first, int op, int dst, int sa, int sb, bit fl);
        bit rv, rep_ok, raw, wb, can, e_fpr, e_fpi, e_imr, e_imi, e_st;
        int rd;
        string tag;
        @(negedge clk);
        im_valid = imv; fp_valid = fpv; fp_first = first; fp_op = 2'(op);
        fp_dst = 5'(dst); fp_src_a = 5'(sa); fp_src_b = 5'(sb); flush = fl;
        #1;
        for (int k = due_q.size() - 1; k >= 0; k--)
            if (due_q[k] < cyc) begin due_q.delete(k); dst_q.delete(k); end
        rv = 0; rd = 0; raw = 0; wb = 0;
        for (int k = 0; k < due_q.size(); k++) begin
            if (due_q[k] == cyc) begin rv = 1; rd = dst_q[k]; end
            if (dst_q[k] == sa || dst_q[k] == sb) raw = 1;
            if (due_q[k] == cyc + m_lat(op)) wb = 1;
        end
        rep_ok = (cyc - last_iss[op]) >= m_rep(op);
        can   = rep_ok && !raw && !wb;
        e_fpr = !fl && can;
        e_fpi = fpv && e_fpr;
        e_imr = !fl && (!(fpv && first) || can);
        e_imi = imv && e_imr;
        e_st  = (fpv && !e_fpi) || (imv && !e_imi);
        tag = fl ? "R8" : !rep_ok ? "R5" : raw ? "R6" : wb ? "R7" : "R2";
        chk(fp_ready, e_fpr, tag, "fp_ready");
        chk(fp_issue, e_fpi, (e_fpi && e_imi) ? "R2" : tag, "fp_issue");
        chk(im_ready, e_imr, "R3", "im_ready");
        chk(im_issue, e_imi, "R3", "im_issue");
        chk(stall, e_st, "R9", "stall");
        chk(res_valid, rv, "R4", "res_valid");
        if (rv) chk(res_dst, rd, "R4", "res_dst");
        if (fl) model_clear();
        else if (e_fpi) begin
            due_q.push_back(cyc + m_lat(op));
            dst_q.push_back(dst);
            last_iss[op] = cyc;
        end
        cyc++;
    endtask

    task automatic idle(int n);
        for (int k = 0; k < n; k++) step(0, 0, 0, 0, 0, 0, 0, 0);
    endtask

    initial begin
        #1000000;
        if (!done) begin
            bad++;
            $display("FAIL watchdog R1 cycle %0d: actual=hung expected=finished", cyc);
            $display("  test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    initial begin
        model_clear();
        repeat (4) @(posedge clk);
        @(negedge clk);
        rst = 1'b0;
        fp_valid = 1'b0; im_valid = 1'b0; fp_op = 2'd2;
        #1;
        // R1: reset state at the ports
        chk(res_valid, 0, "R1", "res_valid after reset");
        chk(stall, 0, "R1", "stall after reset");
        chk(fp_ready, 1, "R1", "fp_ready after reset");
        chk(im_ready, 1, "R1", "im_ready after reset");
        cyc = 0;

        // R2: dual issue, then R4 pulse after 4 cycles
        step(1, 1, 0, 0, 10, 11, 12, 0);
        idle(6);
        // R4: each latency with a distinct destination
        step(0, 1, 0, 3, 13, 1, 2, 0);
        step(0, 1, 0, 1, 14, 1, 2, 0);
        idle(8);
        // R5: double multiply back to back, second waits one cycle
        step(0, 1, 0, 1, 15, 1, 2, 0);
        step(0, 1, 0, 1, 16, 1, 2, 0);
        step(0, 1, 0, 1, 16, 1, 2, 0);
        idle(8);
        // R5: single multiply every cycle, four in flight
        for (int k = 0; k < 5; k++) step(0, 1, 0, 0, 20 + k, 1, 2, 0);
        idle(8);
        // R5: square root spacing of 29, R4 latency 32
        step(0, 1, 0, 2, 26, 1, 2, 0);
        for (int k = 0; k < 31; k++) step(0, 1, 0, 2, 27, 3, 4, 0);
        idle(36);
        // R6: dependent add waits for the multiply pulse; R3 ordering both ways
        step(0, 1, 0, 0, 5, 1, 2, 0);
        for (int k = 0; k < 3; k++) step(1, 1, 1, 3, 6, 5, 2, 0);
        for (int k = 0; k < 3; k++) step(1, 1, 0, 3, 6, 1, 5, 0);
        idle(6);
        // R7: write-back collision, younger waits
        step(0, 1, 0, 1, 8, 1, 2, 0);
        step(1, 1, 1, 0, 9, 1, 2, 0);
        step(0, 1, 0, 0, 9, 1, 2, 0);
        idle(8);
        // R8: flush drops in-flight result and dependency
        step(0, 1, 0, 2, 7, 1, 2, 0);
        step(1, 1, 0, 0, 4, 7, 2, 1);
        step(1, 1, 1, 2, 4, 7, 2, 0);
        idle(40);
        // random mix with a small register set
        for (int k = 0; k < 4000; k++) begin
            step(bit'($urandom_range(0, 1)), $urandom_range(0, 3) != 0,
                 bit'($urandom_range(0, 1)), $urandom_range(0, 3),
                 $urandom_range(0, 5), $urandom_range(0, 5), $urandom_range(0, 5),
                 $urandom_range(0, 63) == 0);
        end
        idle(40);
        done = 1;
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule